// File: doc/BRIEF.md
# Host-Driven Multiply Operand Register File

This block sits between a host CPU's simple 32-bit slave port and a double-precision multiply unit. The host loads operands into a 32-entry, 32-bit register file. It then writes one control/status word that names the operand and result registers, sets the rounding/trap mode and the precision, and starts the operation. Each operand is a pair of adjacent registers that together form a 64-bit value. The multiply unit is combinational and sits outside this block.

A two-state ownership controller decides who may write the register file. In the host state only the CPU can write. The CSR write moves the controller to the unit state for exactly one cycle. In that cycle the 64-bit result is written into a register pair and the five status flags are latched into the control/status word. The controller then returns to the host state. A complete multiply takes four operand writes, one CSR write and two result reads.

Top module: `fmul_rf_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to the host state (`au_busy` = 0) and the control/status word clears to zero. Register contents are not reset.
- R2: Addresses 0 to 31 select register entries. A write stores `cpu_wdata` in the addressed entry. A read is registered: the entry's value appears on `cpu_rdata` in the cycle after the address is presented.
- R3: Address 32 is the control/status word. A CPU write stores only bits [19:0]. Bits [26:20] always read as 0. Flag bits [31:27] cannot be written by the CPU.
- R4: The control/status fields are as follows. Bits [4:0] hold the result index, [9:5] the operand B index, [14:10] the operand A index, and bit 15 the precision select, which drives `au_single`. Bits [19:16] hold the trap/rounding mode, which drives `au_mode`.
- R5: `op_a` equals {entry[A], entry[(A+1) mod 32]}, with the upper word taken from the named index. `op_b` is formed the same way from index B.
- R6: A CPU write to address 32 in the host state makes `au_busy` 1 for exactly one cycle, starting the cycle after the write. The controller then returns to the host state. Without such a write, the controller stays in the host state.
- R7: At the end of the busy cycle, `au_result[63:32]` is written to entry[R] and `au_result[31:0]` to entry[(R+1) mod 32]. `au_flags` is stored in bits [31:27]: bit 31 invalid, 30 underflow, 29 overflow, 28 inexact, 27 divide-by-zero.
- R8: A CPU write presented during the busy cycle is ignored. This holds whether it targets a register entry or the control/status word, and it does not start another operation.
- R9: Writes to addresses 33 to 63 change nothing. Reads from those addresses return 0.
- R10: A result index of 31 wraps: the upper word goes to entry 31 and the lower word to entry 0.
- R11: The host sequence of four operand writes, one control/status write and two result reads returns the unit's full 64-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 6 | Host word address (0-31 registers, 32 control/status) |
| cpu_wdata | input | 32 | Host write data |
| cpu_we | input | 1 | Host write enable |
| cpu_rdata | output | 32 | Registered host read data |
| op_a | output | 64 | Operand A pair to the multiply unit |
| op_b | output | 64 | Operand B pair to the multiply unit |
| au_mode | output | 4 | Trap-enable / rounding-mode controls |
| au_single | output | 1 | Precision select (1 = single) |
| au_busy | output | 1 | Unit owns the register file this cycle |
| au_result | input | 64 | Multiply result from the unit |
| au_flags | input | 5 | Status flags from the unit |

## Verification
The hardest case to reach is a host write that collides with the single busy cycle. A normal host never issues a write in the cycle right after a CSR write, so this only happens with back-to-back stimulus. The bench keeps write enable asserted into the busy cycle, once aimed at an unrelated register and once at the control/status word. It then reads both back and confirms that no second operation started. The sweep runs one operation for every result index, with the operand indices spread across the file, so the wrap at index 31 and pairs that overlap the operands are both covered.

// File: rtl/fmul_rf_pkg.sv
package fmul_rf_pkg;

  // Register file owner: host CPU or arithmetic unit.
  typedef enum logic {
    OWN_HOST = 1'b0,
    OWN_UNIT = 1'b1
  } owner_e;

endpackage

// File: rtl/fmul_rf_owner_fsm.sv
module fmul_rf_owner_fsm
  import fmul_rf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic host_we,
  input  logic csr_hit,
  output logic unit_sel
);

  owner_e state_q;
  owner_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      OWN_HOST: if (host_we && csr_hit) state_d = OWN_UNIT;
      OWN_UNIT: state_d = OWN_HOST;
      default:  state_d = OWN_HOST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= OWN_HOST;
    else     state_q <= state_d;
  end

  assign unit_sel = (state_q == OWN_UNIT);

endmodule

// File: rtl/fmul_rf_csr.sv
module fmul_rf_csr #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5,
  parameter int MODE_W = 4,
  parameter int FLAG_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [3*IDX_W+MODE_W:0] cfg_data,
  input  logic                    flag_we,
  input  logic [FLAG_W-1:0]       flag_in,
  output logic [WORD_W-1:0]       csr_word,
  output logic [IDX_W-1:0]        idx_a,
  output logic [IDX_W-1:0]        idx_b,
  output logic [IDX_W-1:0]        idx_r,
  output logic                    single,
  output logic [MODE_W-1:0]       mode
);

  localparam int CFG_W    = 3*IDX_W + 1 + MODE_W;
  localparam int FLAG_LSB = WORD_W - FLAG_W;
  localparam int GAP_W    = FLAG_LSB - CFG_W;
  localparam int B_LSB    = IDX_W;
  localparam int A_LSB    = 2*IDX_W;
  localparam int PREC_BIT = 3*IDX_W;
  localparam int MODE_LSB = 3*IDX_W + 1;

  logic [CFG_W-1:0]  cfg_q;
  logic [FLAG_W-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      flag_q <= '0;
    end else begin
      if (cfg_we)  cfg_q  <= cfg_data;
      if (flag_we) flag_q <= flag_in;
    end
  end

  assign csr_word = {flag_q, {GAP_W{1'b0}}, cfg_q};
  assign idx_r    = cfg_q[0 +: IDX_W];
  assign idx_b    = cfg_q[B_LSB +: IDX_W];
  assign idx_a    = cfg_q[A_LSB +: IDX_W];
  assign single   = cfg_q[PREC_BIT];
  assign mode     = cfg_q[MODE_LSB +: MODE_W];

endmodule

// File: rtl/fmul_rf_storage.sv
module fmul_rf_storage #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                       clk,
  input  logic                       host_we,
  input  logic [IDX_W-1:0]           host_idx,
  input  logic [WORD_W-1:0]          host_wdata,
  output logic [WORD_W-1:0]          host_rdata,
  input  logic                       unit_we,
  input  logic [IDX_W-1:0]           unit_idx,
  input  logic [2*WORD_W-1:0]        unit_data,
  input  logic [1:0][IDX_W-1:0]      pair_idx,
  output logic [1:0][2*WORD_W-1:0]   pair_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  unit_nxt;

  assign unit_nxt = unit_idx + 1'b1;

  // Unit write has priority; the host is locked out while it owns the file.
  always_ff @(posedge clk) begin
    if (unit_we) begin
      mem[unit_idx] <= unit_data[2*WORD_W-1:WORD_W];
      mem[unit_nxt] <= unit_data[WORD_W-1:0];
    end else if (host_we) begin
      mem[host_idx] <= host_wdata;
    end
  end

  assign host_rdata = mem[host_idx];

  for (genvar g = 0; g < 2; g++) begin : g_pair
    logic [IDX_W-1:0] nxt;
    assign nxt          = pair_idx[g] + 1'b1;
    assign pair_data[g] = {mem[pair_idx[g]], mem[nxt]};
  end

endmodule

// File: rtl/fmul_rf_ctrl.sv
module fmul_rf_ctrl #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5,
  parameter int MODE_W = 4,
  parameter int FLAG_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W:0]        cpu_addr,
  input  logic [WORD_W-1:0]     cpu_wdata,
  input  logic                  cpu_we,
  output logic [WORD_W-1:0]     cpu_rdata,
  output logic [2*WORD_W-1:0]   op_a,
  output logic [2*WORD_W-1:0]   op_b,
  output logic [MODE_W-1:0]     au_mode,
  output logic                  au_single,
  output logic                  au_busy,
  input  logic [2*WORD_W-1:0]   au_result,
  input  logic [FLAG_W-1:0]     au_flags
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int CFG_W = 3*IDX_W + 1 + MODE_W;
  localparam logic [IDX_W:0] CSR_ADDR = (IDX_W+1)'(DEPTH);

  logic                      csr_hit;
  logic                      rf_hit;
  logic                      rf_we;
  logic                      cfg_we;
  logic [WORD_W-1:0]         csr_word;
  logic [WORD_W-1:0]         host_rd;
  logic [IDX_W-1:0]          idx_a;
  logic [IDX_W-1:0]          idx_b;
  logic [IDX_W-1:0]          idx_r;
  logic [1:0][IDX_W-1:0]     pair_idx;
  logic [1:0][2*WORD_W-1:0]  pair_data;
  logic [WORD_W-1:0]         rdata_q;

  assign csr_hit = (cpu_addr == CSR_ADDR);
  assign rf_hit  = ~cpu_addr[IDX_W];
  assign rf_we   = cpu_we & rf_hit & ~au_busy;
  assign cfg_we  = cpu_we & csr_hit & ~au_busy;

  fmul_rf_owner_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .host_we  (cpu_we),
    .csr_hit  (csr_hit),
    .unit_sel (au_busy)
  );

  fmul_rf_csr #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W),
    .MODE_W (MODE_W),
    .FLAG_W (FLAG_W)
  ) u_csr (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_data (cpu_wdata[CFG_W-1:0]),
    .flag_we  (au_busy),
    .flag_in  (au_flags),
    .csr_word (csr_word),
    .idx_a    (idx_a),
    .idx_b    (idx_b),
    .idx_r    (idx_r),
    .single   (au_single),
    .mode     (au_mode)
  );

  assign pair_idx[0] = idx_a;
  assign pair_idx[1] = idx_b;

  fmul_rf_storage #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk        (clk),
    .host_we    (rf_we),
    .host_idx   (cpu_addr[IDX_W-1:0]),
    .host_wdata (cpu_wdata),
    .host_rdata (host_rd),
    .unit_we    (au_busy),
    .unit_idx   (idx_r),
    .unit_data  (au_result),
    .pair_idx   (pair_idx),
    .pair_data  (pair_data)
  );

  assign op_a = pair_data[0];
  assign op_b = pair_data[1];

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (csr_hit) rdata_q <= csr_word;
    else if (rf_hit)  rdata_q <= host_rd;
    else              rdata_q <= '0;
  end

  assign cpu_rdata = rdata_q;

endmodule

// File: rtl/fmul_rf_chk.sv
module fmul_rf_chk #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5,
  parameter int MODE_W = 4,
  parameter int FLAG_W = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cpu_we,
  input logic                    csr_hit,
  input logic [3*IDX_W+MODE_W:0] cfg_wdata,
  input logic                    au_busy,
  input logic [FLAG_W-1:0]       au_flags,
  input logic [WORD_W-1:0]       csr_word
);

  localparam int CFG_W    = 3*IDX_W + 1 + MODE_W;
  localparam int FLAG_LSB = WORD_W - FLAG_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!au_busy && csr_word == '0));

  // R6
  trigger_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && csr_hit && !au_busy) |=> au_busy);

  // R6
  busy_single_chk: assert property (@(posedge clk) disable iff (rst)
    au_busy |=> !au_busy);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!au_busy && !(cpu_we && csr_hit)) |=> !au_busy);

  // R7
  flag_capture_chk: assert property (@(posedge clk) disable iff (rst)
    au_busy |=> csr_word[WORD_W-1:FLAG_LSB] == $past(au_flags));

  // R8
  busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    au_busy |=> csr_word[CFG_W-1:0] == $past(csr_word[CFG_W-1:0]));

  // R3
  cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && csr_hit && !au_busy) |=> csr_word[CFG_W-1:0] == $past(cfg_wdata));

endmodule

bind fmul_rf_ctrl fmul_rf_chk #(
  .WORD_W (WORD_W),
  .IDX_W  (IDX_W),
  .MODE_W (MODE_W),
  .FLAG_W (FLAG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_we    (cpu_we),
  .csr_hit   (csr_hit),
  .cfg_wdata (cpu_wdata[CFG_W-1:0]),
  .au_busy   (au_busy),
  .au_flags  (au_flags),
  .csr_word  (csr_word)
);

// File: tb/tb_fmul_rf_ctrl.sv
`timescale 1ns/1ps
module tb_fmul_rf_ctrl;

  localparam logic [5:0] CSR = 6'd32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_rdata;
  logic [63:0] op_a, op_b, au_result;
  logic [3:0]  au_mode;
  logic        au_single, au_busy;
  logic [4:0]  au_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  fmul_rf_ctrl dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .op_a(op_a), .op_b(op_b),
    .au_mode(au_mode), .au_single(au_single), .au_busy(au_busy),
    .au_result(au_result), .au_flags(au_flags)
  );

  // Stand-in arithmetic unit: any fixed function of the operands will do.
  function automatic logic [63:0] stub_res(logic [63:0] a, logic [63:0] b,
                                           logic sg, logic [3:0] md);
    return (a ^ {b[31:0], b[63:32]}) + {59'd0, sg, md};
  endfunction

  always_comb begin
    au_result = stub_res(op_a, op_b, au_single, au_mode);
    au_flags  = op_a[4:0] ^ op_b[9:5];
  end

  function automatic logic [31:0] pat(int k);
    return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_we = 1'b0;
    @(negedge clk); d = cpu_rdata;
  endtask

  // kind: 0 none, 1 register write in busy cycle, 2 CSR write in busy cycle
  task automatic do_op(int ia, int ib, int ir, logic [3:0] md, logic sg,
                       logic [11:0] junk, int kind, logic [5:0] xa, logic [31:0] xd);
    logic [31:0] cfg, d;
    logic [63:0] ea, eb, er;
    logic [4:0]  ef;
    cfg = {12'd0, md, sg, 5'(ia), 5'(ib), 5'(ir)};
    ea  = {model[ia], model[(ia+1)%32]};
    eb  = {model[ib], model[(ib+1)%32]};
    er  = stub_res(ea, eb, sg, md);
    ef  = ea[4:0] ^ eb[9:5];
    @(negedge clk); cpu_addr = CSR; cpu_wdata = cfg | {junk, 20'd0}; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = (kind != 0); cpu_addr = xa; cpu_wdata = xd;
    chk("R6 busy after CSR write", {63'd0, au_busy}, 64'd1);
    chk("R5 operand A pair", op_a, ea);
    chk("R5 operand B pair", op_b, eb);
    chk("R4 mode field", {60'd0, au_mode}, {60'd0, md});
    chk("R4 precision bit", {63'd0, au_single}, {63'd0, sg});
    @(negedge clk); cpu_we = 1'b0;
    chk("R6 R8 back to host after one cycle", {63'd0, au_busy}, 64'd0);
    model[ir] = er[63:32];
    model[(ir+1)%32] = er[31:0];
    rd(6'(ir), d);
    chk(ir == 31 ? "R10 R11 upper word" : "R7 R11 upper word", {32'd0, d}, {32'd0, er[63:32]});
    rd(6'((ir+1)%32), d);
    chk(ir == 31 ? "R10 R11 lower word wrapped" : "R7 R11 lower word", {32'd0, d}, {32'd0, er[31:0]});
    rd(CSR, d);
    chk("R3 R7 R8 status word", {32'd0, d}, {32'd0, ef, 7'd0, cfg[19:0]});
    if (kind == 1) begin
      rd(xa, d);
      chk("R8 register write in busy cycle ignored", {32'd0, d}, {32'd0, model[xa]});
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 idle after reset", {63'd0, au_busy}, 64'd0);
    rd(CSR, d);
    chk("R1 status word cleared", {32'd0, d}, 64'd0);

    // R2: every entry written then read back
    for (int i = 0; i < 32; i++) begin
      model[i] = pat(i);
      wr(6'(i), model[i]);
    end
    for (int i = 0; i < 32; i++) begin
      rd(6'(i), d);
      chk("R2 entry readback", {32'd0, d}, {32'd0, model[i]});
    end

    // R9: unmapped addresses
    for (int a = 33; a < 64; a++) wr(6'(a), 32'hFFFF_FFFF);
    for (int a = 33; a < 64; a += 5) begin
      rd(6'(a), d);
      chk("R9 unmapped read zero", {32'd0, d}, 64'd0);
    end
    for (int i = 0; i < 32; i++) begin
      rd(6'(i), d);
      chk("R9 entries untouched", {32'd0, d}, {32'd0, model[i]});
    end

    // R3: junk in the upper bits must not reach flags or reserved bits
    do_op(31, 31, 31, 4'hF, 1'b1, 12'hFFF, 0, 6'd0, 32'd0);

    // Sweep of result index with host sequence reloading operands (R11)
    for (int r = 0; r < 32; r++) begin
      int ia, ib;
      ia = (r*7 + 3) % 32;
      ib = (r*13 + 1) % 32;
      model[ia] = pat(r + 100); wr(6'(ia), model[ia]);
      model[(ia+1)%32] = pat(r + 200); wr(6'((ia+1)%32), model[(ia+1)%32]);
      model[ib] = pat(r + 300); wr(6'(ib), model[ib]);
      model[(ib+1)%32] = pat(r + 400); wr(6'((ib+1)%32), model[(ib+1)%32]);
      do_op(ia, ib, r, 4'(r), r[0], 12'd0, 0, 6'd0, 32'd0);
    end

    // R8: collisions in the busy cycle
    do_op(2, 6, 10, 4'h5, 1'b0, 12'd0, 1, 6'd20, 32'hDEAD_BEEF);
    do_op(4, 8, 12, 4'hA, 1'b1, 12'd0, 2, CSR, 32'h000F_FFFF);
    chk("R8 CSR write in busy cycle no retrigger", {63'd0, au_busy}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule